// File: doc/BRIEF.md
# Parallel Port Peripheral Handshake Controller

This block is the peripheral end of a byte-wide parallel link to a host computer. The host drives two active-low request strobes, one for address cycles and one for data cycles. It also drives a direction line and a byte-wide bus, and it waits on a single ready line that the peripheral drives. The host sends no clock. Both strobes are therefore fully asynchronous to the local clock, and each one passes through its own flip-flop chain before the control logic sees it.

A cycle moves through four phases:

1. The host pulls one strobe low while ready is low.
2. The peripheral raises ready to acknowledge.
3. The peripheral holds ready for a fixed number of clocks, then drops it.
4. The host releases the strobe.

On the inside, the block keeps an address register. Address-write cycles load that register. Data-write cycles issue a single-clock write pulse that carries the stored address. Read cycles drive a captured byte back onto the bus: the address register for an address read, and the register file's read data for a data read.

The direction line and the bus are not synchronised. The protocol keeps them stable while a strobe is low, so they are sampled once, on the clock edge where the synchronised strobe is first acted on.

Top module: `pport_periph`

## Requirements
- R1: A synchronous reset (rst high) drives ready, busOe, regWrEn and protoErr low, clears regAddr to zero, and returns the block to its waiting state with both synchronised strobes inactive (high).
- R2: Each strobe passes through SYNC_STAGES (default 2) flip-flops. With the defaults, ready rises on the third rising clock edge that samples a strobe low, which is 3 clocks after the strobe falls.
- R3: Ready stays high for exactly ACK_HOLD clocks (default 2) and then falls. It does not rise again until the active strobe has been seen high and then low again.
- R4: An address cycle with hostWrite=1 loads busIn into the address register, which is seen on regAddr, on the acknowledge edge.
- R5: A data cycle with hostWrite=1 raises regWrEn for exactly one clock, in the same clock that ready first reads high. In that clock, regWrData holds the busIn byte and regAddr holds the stored address.
- R6: A data cycle with hostWrite=0 raises busOe together with ready. busOe falls one clock after the released strobe is seen by the synchroniser. busOut holds regRdData as it was at the acknowledge edge.
- R7: An address cycle with hostWrite=0 drives busOut with the address register value, under the same busOe timing as R6.
- R8: If both synchronised strobes are low when a cycle starts, the address cycle wins and the data cycle is ignored: no regWrEn pulse is issued. protoErr goes high and stays high until reset.
- R9: busIn and hostWrite are sampled only on the acknowledge edge. Later changes to busIn during the cycle do not alter regAddr or regWrData.
- R10: A strobe held low long after ready falls produces no second acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous reset, active high |
| addrStrobeN | input | 1 | Asynchronous address-cycle request, active low |
| dataStrobeN | input | 1 | Asynchronous data-cycle request, active low |
| hostWrite | input | 1 | Direction from host: 1 = host writes, 0 = host reads |
| busIn | input | DATA_W | Bus value driven by the host |
| busOut | output | DATA_W | Bus value driven by the peripheral on reads |
| busOe | output | 1 | Bus output enable for busOut |
| ready | output | 1 | Acknowledge to host |
| regAddr | output | DATA_W | Current address register |
| regWrEn | output | 1 | One-clock register write pulse |
| regWrData | output | DATA_W | Write data for regWrEn |
| regRdData | input | DATA_W | Register read data for regAddr |
| protoErr | output | 1 | Sticky flag: both strobes seen low at cycle start |

## Verification
The main function is tried with five patterns:
- address writes and data writes, which separate loading the address register from issuing a write pulse;
- data reads and address reads, which separate the two sources that drive the bus;
- a strobe held low long after ready drops, which shows that a stale request is refused;
- both strobes pulled low together, which exposes the priority rule and the sticky error flag;
- a bus value changed after the acknowledge, which shows the single sampling point.

A behavioural model of the four phases runs beside the design every clock. Latency counts and ready pulse widths are measured at the host side of the link.

// File: rtl/pport_pkg.sv
package pport_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ACK     = 2'd1,
    ST_RELEASE = 2'd2
  } hsState_t;

  typedef struct packed {
    logic capAddr;   // address write: load register from bus
    logic capWrite;  // data write: issue write pulse
    logic capRead;   // read: capture bus output, enable driver
    logic readAddr;  // read source is the address register
    logic endCycle;  // strobe release seen, drop driver
  } dpCtl_t;
endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  // Plain flop chain, nothing between stages, reset to inactive high.
  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b1;
        else     chain[0] <= asyncIn;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= 1'b1;
        else     chain[i] <= chain[i-1];
      end
    end
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/pport_ctrl.sv
module pport_ctrl
  import pport_pkg::*;
#(
  parameter int ACK_HOLD = 2
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   addrSeenN,
  input  logic   dataSeenN,
  input  logic   hostWrite,
  output logic   ready,
  output logic   protoErr,
  output dpCtl_t ctl
);
  localparam int CNT_W = (ACK_HOLD > 1) ? $clog2(ACK_HOLD) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ACK_HOLD - 1);

  hsState_t       state;
  logic [CNT_W-1:0] holdCnt;
  logic           cycIsAddr;
  logic           startCyc;
  logic           startAddr;
  logic           releaseSeen;

  always_comb begin
    startAddr   = !addrSeenN;
    startCyc    = (state == ST_IDLE) && (!addrSeenN || !dataSeenN);
    releaseSeen = cycIsAddr ? addrSeenN : dataSeenN;
    ctl.capAddr  = startCyc && startAddr && hostWrite;
    ctl.capWrite = startCyc && !startAddr && hostWrite;
    ctl.capRead  = startCyc && !hostWrite;
    ctl.readAddr = startAddr;
    ctl.endCycle = (state == ST_RELEASE) && releaseSeen;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      holdCnt   <= '0;
      ready     <= 1'b0;
      protoErr  <= 1'b0;
      cycIsAddr <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (startCyc) begin
            state     <= ST_ACK;
            ready     <= 1'b1;
            holdCnt   <= '0;
            cycIsAddr <= startAddr;
            if (!addrSeenN && !dataSeenN) protoErr <= 1'b1;
          end
        end
        ST_ACK: begin
          if (holdCnt == CNT_LAST) begin
            state <= ST_RELEASE;
            ready <= 1'b0;
          end else begin
            holdCnt <= holdCnt + 1'b1;
          end
        end
        ST_RELEASE: begin
          if (releaseSeen) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pport_dpath.sv
module pport_dpath
  import pport_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  dpCtl_t            ctl,
  input  logic [DATA_W-1:0] busIn,
  input  logic [DATA_W-1:0] regRdData,
  output logic [DATA_W-1:0] addrReg,
  output logic              wrEn,
  output logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] busOut,
  output logic              busOe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addrReg <= '0;
      wrEn    <= 1'b0;
      wrData  <= '0;
      busOut  <= '0;
      busOe   <= 1'b0;
    end else begin
      wrEn <= ctl.capWrite;
      if (ctl.capAddr)  addrReg <= busIn;
      if (ctl.capWrite) wrData  <= busIn;
      if (ctl.capRead) begin
        busOut <= ctl.readAddr ? addrReg : regRdData;
        busOe  <= 1'b1;
      end else if (ctl.endCycle) begin
        busOe <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pport_periph.sv
module pport_periph
  import pport_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int ACK_HOLD    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addrStrobeN,
  input  logic              dataStrobeN,
  input  logic              hostWrite,
  input  logic [DATA_W-1:0] busIn,
  output logic [DATA_W-1:0] busOut,
  output logic              busOe,
  output logic              ready,
  output logic [DATA_W-1:0] regAddr,
  output logic              regWrEn,
  output logic [DATA_W-1:0] regWrData,
  input  logic [DATA_W-1:0] regRdData,
  output logic              protoErr
);
  localparam int N_STROBES = 2;

  logic [N_STROBES-1:0] strobeRaw;
  logic [N_STROBES-1:0] strobeSeen;
  dpCtl_t               ctl;

  assign strobeRaw = {dataStrobeN, addrStrobeN};

  for (genvar s = 0; s < N_STROBES; s++) begin : g_sync
    pport_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst     (rst),
      .asyncIn (strobeRaw[s]),
      .syncOut (strobeSeen[s])
    );
  end

  pport_ctrl #(.ACK_HOLD(ACK_HOLD)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .addrSeenN (strobeSeen[0]),
    .dataSeenN (strobeSeen[1]),
    .hostWrite (hostWrite),
    .ready     (ready),
    .protoErr  (protoErr),
    .ctl       (ctl)
  );

  pport_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk       (clk),
    .rst       (rst),
    .ctl       (ctl),
    .busIn     (busIn),
    .regRdData (regRdData),
    .addrReg   (regAddr),
    .wrEn      (regWrEn),
    .wrData    (regWrData),
    .busOut    (busOut),
    .busOe     (busOe)
  );
endmodule

// File: rtl/pport_chk.sv
module pport_chk (
  input logic clk,
  input logic rst,
  input logic addrStrobeN,
  input logic dataStrobeN,
  input logic ready,
  input logic busOe,
  input logic regWrEn,
  input logic protoErr
);
  // R2
  ack_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> ($past(!addrStrobeN, 2) || $past(!dataStrobeN, 2)));

  // R3
  no_back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ready) |=> !ready);

  // R5
  wr_pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    regWrEn |=> !regWrEn);

  // R5
  wr_with_ack_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(regWrEn) |-> $rose(ready));

  // R6
  oe_not_on_write_chk: assert property (@(posedge clk) disable iff (rst)
    !(busOe && regWrEn));

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    protoErr |=> protoErr);
endmodule

bind pport_periph pport_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .addrStrobeN (addrStrobeN),
  .dataStrobeN (dataStrobeN),
  .ready       (ready),
  .busOe       (busOe),
  .regWrEn     (regWrEn),
  .protoErr    (protoErr)
);

// File: tb/sim_pport_periph.sv
`timescale 1ns/1ps
module sim_pport_periph;
  localparam int HOLD = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       addrStrobeN = 1'b1;
  logic       dataStrobeN = 1'b1;
  logic       hostWrite = 1'b0;
  logic [7:0] busIn = 8'h00;
  logic [7:0] busOut;
  logic       busOe;
  logic       ready;
  logic [7:0] regAddr;
  logic       regWrEn;
  logic [7:0] regWrData;
  logic [7:0] regRdData;
  logic       protoErr;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  assign regRdData = regAddr ^ 8'hA5;

  pport_periph u0 (
    .clk(clk), .rst(rst), .addrStrobeN(addrStrobeN), .dataStrobeN(dataStrobeN),
    .hostWrite(hostWrite), .busIn(busIn), .busOut(busOut), .busOe(busOe),
    .ready(ready), .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .protoErr(protoErr)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model of the four-phase handshake.
  bit   aPipe[$];
  bit   dPipe[$];
  int   mPhase;
  int   mCnt;
  bit   mIsAddr;
  bit   mReady, mOe, mWrEn, mErr;
  int   mAddr, mWrData, mOut;

  always @(posedge clk) begin
    bit aSeen, dSeen;
    if (rst) begin
      aPipe = '{1, 1}; dPipe = '{1, 1};
      mPhase = 0; mCnt = 0; mIsAddr = 0;
      mReady = 0; mOe = 0; mWrEn = 0; mErr = 0;
      mAddr = 0; mWrData = 0; mOut = 0;
    end else begin
      aSeen = aPipe[1]; dSeen = dPipe[1];
      aPipe.push_front(addrStrobeN); void'(aPipe.pop_back());
      dPipe.push_front(dataStrobeN); void'(dPipe.pop_back());
      mWrEn = 0;
      if (mPhase == 0) begin
        if (!aSeen || !dSeen) begin
          mIsAddr = !aSeen;
          if (!aSeen && !dSeen) mErr = 1;
          mPhase = 1; mCnt = 0; mReady = 1;
          if (hostWrite) begin
            if (mIsAddr) mAddr = busIn;
            else begin mWrEn = 1; mWrData = busIn; end
          end else begin
            mOe = 1;
            mOut = mIsAddr ? mAddr : (mAddr ^ 8'hA5);
          end
        end
      end else if (mPhase == 1) begin
        if (mCnt == HOLD - 1) begin mPhase = 2; mReady = 0; end
        else mCnt++;
      end else begin
        if (mIsAddr ? aSeen : dSeen) begin mPhase = 0; mOe = 0; end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R3 ready vs model", ready, mReady);
      check("R6 busOe vs model", busOe, mOe);
      check("R5 regWrEn vs model", regWrEn, mWrEn);
      check("R4 regAddr vs model", regAddr, mAddr);
      check("R8 protoErr vs model", protoErr, mErr);
      if (mWrEn) check("R5 regWrData vs model", regWrData, mWrData);
      if (mOe)   check("R6 busOut vs model", busOut, mOut);
    end
  end

  int  lat, hi;
  bit  reAck;
  logic wrAtAck, oeAtAck;
  logic [7:0] outAtAck, wdAtAck, addrAtAck;

  task automatic hostCycle(input bit isAddr, input bit wr, input logic [7:0] d,
                           input int extraHold, input bit bothLow);
    @(negedge clk);
    hostWrite = wr; busIn = d;
    if (isAddr || bothLow)  addrStrobeN = 1'b0;
    if (!isAddr || bothLow) dataStrobeN = 1'b0;
    lat = 0;
    while (!ready && lat < 50) begin @(negedge clk); lat++; end
    wrAtAck = regWrEn; oeAtAck = busOe; outAtAck = busOut;
    wdAtAck = regWrData; addrAtAck = regAddr;
    busIn = ~d;
    hi = 0;
    while (ready && hi < 50) begin @(negedge clk); hi++; end
    reAck = 0;
    for (int k = 0; k < extraHold; k++) begin
      @(negedge clk);
      if (ready) reAck = 1;
    end
    addrStrobeN = 1'b1; dataStrobeN = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1 ready at reset", ready, 0);
    check("R1 busOe at reset", busOe, 0);
    check("R1 regWrEn at reset", regWrEn, 0);
    check("R1 protoErr at reset", protoErr, 0);
    check("R1 regAddr at reset", regAddr, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    hostCycle(1, 1, 8'h3C, 0, 0);
    check("R2 ack latency", lat, 3);
    check("R3 ready width", hi, HOLD);
    check("R4 address loaded", regAddr, 8'h3C);
    check("R9 address stable after bus change", addrAtAck, 8'h3C);

    hostCycle(0, 1, 8'h5A, 0, 0);
    check("R5 write pulse with ack", wrAtAck, 1);
    check("R5 write data", wdAtAck, 8'h5A);
    check("R5 write address", addrAtAck, 8'h3C);
    check("R9 write data kept", regWrData, 8'h5A);
    check("R9 address untouched by data write", regAddr, 8'h3C);

    hostCycle(0, 0, 8'h00, 0, 0);
    check("R6 oe with ack", oeAtAck, 1);
    check("R6 read data", outAtAck, 8'h3C ^ 8'hA5);
    check("R6 no write on read", wrAtAck, 0);
    check("R6 oe dropped after release", busOe, 0);

    hostCycle(1, 0, 8'h00, 0, 0);
    check("R7 address readback", outAtAck, 8'h3C);
    check("R7 oe with ack", oeAtAck, 1);

    hostCycle(0, 1, 8'h11, 10, 0);
    check("R10 no second ack while held", reAck, 0);
    check("R10 first ack width", hi, HOLD);

    hostCycle(0, 1, 8'h77, 0, 1);
    check("R8 error flagged", protoErr, 1);
    check("R8 address priority", regAddr, 8'h77);
    check("R8 data cycle suppressed", wrAtAck, 0);

    hostCycle(0, 1, 8'h22, 0, 0);
    check("R8 error sticky", protoErr, 1);
    check("R5 write after error", wdAtAck, 8'h22);

    finishRun();
  end
endmodule